// File: doc/BRIEF.md
# Frequency-Compensated PTP Time-of-Day Counter

This block keeps a nanosecond time-of-day value for a precision time protocol clock. The timer reference is one of four tick sources, each presented as a one-cycle enable in the system clock domain. A two-bit selector picks the source. Every enabled tick from that source adds a programmable fractional addend into a phase accumulator. A carry out of the accumulator's top bit advances the time value by a programmed nominal period in nanoseconds. The counter therefore runs at the nominal rate and not at the reference rate.

Software programs the addend as ceil(2^ACC_W / R). Here R is the reference rate divided by the nominal rate, and R must exceed 1.0. Software trims the frequency by rewriting the addend while the counter runs. The largest usable trim, in parts per billion, is 10^9·(R−1)−1. Each advance raises a one-cycle strobe, which downstream pulse generators use. The configuration is reached through a small write port with one word address per setting.

Top module: `ptp_tod_counter`

## Requirements
- R1: After reset the time output is 0, the strobe is low, the counter is disabled, the accumulator holds 0, the nominal period is DEF_PERIOD (10), the addend is DEF_ADDEND (0x8000_0000), and the source selector is 1 (system clock).
- R2: Each enabled tick from the selected source adds the addend to the ACC_W-bit accumulator modulo 2^ACC_W.
- R3: When that addition carries out of the accumulator, the time output grows by the nominal period at the same clock edge. tod_strobe is high for exactly the following cycle.
- R4: When an accumulation does not carry, or no enabled tick arrives, the time output holds and tod_strobe stays low.
- R5: Selector value n (0 external precision timer, 1 system clock, 2 transmit clock, 3 RTC) makes ref_ticks[n] the only tick input that has any effect.
- R6: While the enable bit is 0, ticks change neither the accumulator nor the time output.
- R7: A write to the addend applies from the first tick after the write edge. The accumulator residue is kept across the write.
- R8: The time output wraps modulo 2^TIME_W.
- R9: Register writes use wr_addr as follows: 0 enable (bit 0), 1 source selector (low SEL_W bits), 2 nominal period (low PERIOD_W bits), 3 addend (low ACC_W bits). A write lands at the clock edge. A tick in the same cycle still uses the old setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register word address |
| wr_data | input | DATA_W | Register write data |
| ref_ticks | input | NSRC | One-cycle tick enables of the candidate reference sources |
| tod | output | TIME_W | Time of day in nanoseconds |
| tod_strobe | output | 1 | One-cycle pulse after each time advance |

## Verification
The hardest case to reach from the ports is the wrap of the time value. No load port exists, and a 64-bit nanosecond count cannot come near its limit in a short run. The bench therefore drives a second instance, built with a 16-bit time width, from the same stimulus. It programs a large period and an addend just below 2^32, so nearly every tick carries and the narrow counter wraps many times. The other delicate case is residue preservation across an addend change. The bench rewrites the addend while the accumulator sits at a known non-zero phase and checks the exact tick on which the next carry appears.

// File: rtl/ptp_tod_pkg.sv
package ptp_tod_pkg;

   typedef enum logic [1:0] {
      SRC_EXT_PRECISION = 2'd0,
      SRC_SYSTEM        = 2'd1,
      SRC_TRANSMIT      = 2'd2,
      SRC_RTC           = 2'd3
   } ref_src_e;

   localparam logic [1:0] REG_ENABLE = 2'd0;
   localparam logic [1:0] REG_SOURCE = 2'd1;
   localparam logic [1:0] REG_PERIOD = 2'd2;
   localparam logic [1:0] REG_ADDEND = 2'd3;

endpackage

// File: rtl/tod_cfg_regs.sv
module tod_cfg_regs
   import ptp_tod_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter int ACC_W      = 32,
   parameter int PERIOD_W   = 32,
   parameter int SEL_W      = 2,
   parameter logic [PERIOD_W-1:0] DEF_PERIOD = 10,
   parameter logic [ACC_W-1:0]    DEF_ADDEND = 32'h8000_0000
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                wr_en,
   input  logic [1:0]          wr_addr,
   input  logic [DATA_W-1:0]   wr_data,
   output logic                enable,
   output logic [SEL_W-1:0]    src_sel,
   output logic [PERIOD_W-1:0] period,
   output logic [ACC_W-1:0]    addend
);

   localparam logic [SEL_W-1:0] DEF_SEL = SEL_W'(int'(SRC_SYSTEM));

   always_ff @(posedge clk) begin
      if (rst) begin
         enable  <= 1'b0;
         src_sel <= DEF_SEL;
         period  <= DEF_PERIOD;
         addend  <= DEF_ADDEND;
      end else if (wr_en) begin
         case (wr_addr)
            REG_ENABLE: enable  <= wr_data[0];
            REG_SOURCE: src_sel <= wr_data[SEL_W-1:0];
            REG_PERIOD: period  <= wr_data[PERIOD_W-1:0];
            REG_ADDEND: addend  <= wr_data[ACC_W-1:0];
            default:    ;
         endcase
      end
   end

   AST_WRITE_ADDEND: assert property (@(posedge clk) disable iff (rst)
      ($past(wr_en) && $past(wr_addr) == REG_ADDEND) |-> addend == $past(wr_data[ACC_W-1:0])); // R9

   AST_ENABLE_HOLD: assert property (@(posedge clk) disable iff (rst)
      !$past(wr_en) |-> $stable(enable)); // R9

endmodule

// File: rtl/tod_ref_select.sv
module tod_ref_select #(
   parameter int NSRC  = 4,
   parameter int SEL_W = 2
) (
   input  logic [NSRC-1:0]  src_tick,
   input  logic [SEL_W-1:0] src_sel,
   input  logic             enable,
   output logic             ref_tick
);

   logic [NSRC-1:0] pick;

   for (genvar i = 0; i < NSRC; i++) begin : g_pick
      assign pick[i] = (src_sel == SEL_W'(i)) & src_tick[i];
   end

   assign ref_tick = enable & (|pick);

endmodule

// File: rtl/tod_phase_acc.sv
module tod_phase_acc #(
   parameter int ACC_W = 32
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             ref_tick,
   input  logic [ACC_W-1:0] addend,
   output logic             carry,
   output logic [ACC_W-1:0] phase
);

   logic [ACC_W:0] sum;

   assign sum   = {1'b0, phase} + {1'b0, addend};
   assign carry = ref_tick & sum[ACC_W];

   always_ff @(posedge clk) begin
      if (rst)           phase <= '0;
      else if (ref_tick) phase <= sum[ACC_W-1:0];
   end

   AST_PHASE_ADVANCE: assert property (@(posedge clk) disable iff (rst)
      $past(ref_tick) |-> phase == ACC_W'($past(phase) + $past(addend))); // R2

   AST_PHASE_IDLE: assert property (@(posedge clk) disable iff (rst)
      !$past(ref_tick) |-> $stable(phase)); // R6

endmodule

// File: rtl/tod_time_reg.sv
module tod_time_reg #(
   parameter int TIME_W   = 64,
   parameter int PERIOD_W = 32
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                advance,
   input  logic [PERIOD_W-1:0] period,
   output logic [TIME_W-1:0]   tod,
   output logic                strobe
);

   logic [TIME_W-1:0] step;

   if (TIME_W == PERIOD_W) begin : g_same_w
      assign step = period;
   end else begin : g_zext
      assign step = {{(TIME_W-PERIOD_W){1'b0}}, period};
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         tod    <= '0;
         strobe <= 1'b0;
      end else begin
         strobe <= advance;
         if (advance) tod <= tod + step;
      end
   end

   AST_STROBE_STEP: assert property (@(posedge clk) disable iff (rst)
      strobe |-> tod == TIME_W'($past(tod) + TIME_W'($past(period)))); // R3

   AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (rst)
      !strobe |-> $stable(tod)); // R4

endmodule

// File: rtl/ptp_tod_counter.sv
module ptp_tod_counter
   import ptp_tod_pkg::*;
#(
   parameter int TIME_W   = 64,
   parameter int PERIOD_W = 32,
   parameter int ACC_W    = 32,
   parameter int DATA_W   = 32,
   parameter int NSRC     = 4,
   parameter logic [PERIOD_W-1:0] DEF_PERIOD = 10,
   parameter logic [ACC_W-1:0]    DEF_ADDEND = 32'h8000_0000
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic [1:0]        wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [NSRC-1:0]   ref_ticks,
   output logic [TIME_W-1:0] tod,
   output logic              tod_strobe
);

   localparam int SEL_W = (NSRC > 1) ? $clog2(NSRC) : 1;

   if (PERIOD_W > TIME_W) begin : g_bad_period
      $error("PERIOD_W must not exceed TIME_W");
   end
   if (ACC_W > DATA_W || PERIOD_W > DATA_W || SEL_W > DATA_W) begin : g_bad_data
      $error("a register field is wider than DATA_W");
   end
   if (NSRC < 2 || int'(SRC_SYSTEM) >= NSRC) begin : g_bad_nsrc
      $error("NSRC must cover the default system clock source");
   end

   logic                enable;
   logic [SEL_W-1:0]    src_sel;
   logic [PERIOD_W-1:0] period;
   logic [ACC_W-1:0]    addend;
   logic                ref_tick;
   logic                carry;
   logic [ACC_W-1:0]    phase;

   tod_cfg_regs #(
      .DATA_W(DATA_W), .ACC_W(ACC_W), .PERIOD_W(PERIOD_W), .SEL_W(SEL_W),
      .DEF_PERIOD(DEF_PERIOD), .DEF_ADDEND(DEF_ADDEND)
   ) u_cfg (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .enable(enable), .src_sel(src_sel), .period(period), .addend(addend)
   );

   tod_ref_select #(.NSRC(NSRC), .SEL_W(SEL_W)) u_sel (
      .src_tick(ref_ticks), .src_sel(src_sel), .enable(enable), .ref_tick(ref_tick)
   );

   tod_phase_acc #(.ACC_W(ACC_W)) u_acc (
      .clk(clk), .rst(rst), .ref_tick(ref_tick), .addend(addend),
      .carry(carry), .phase(phase)
   );

   tod_time_reg #(.TIME_W(TIME_W), .PERIOD_W(PERIOD_W)) u_time (
      .clk(clk), .rst(rst), .advance(carry), .period(period),
      .tod(tod), .strobe(tod_strobe)
   );

   AST_CARRY_TO_STROBE: assert property (@(posedge clk) disable iff (rst)
      $past(carry) |-> tod_strobe); // R3

   AST_DISABLED_FROZEN: assert property (@(posedge clk) disable iff (rst)
      !$past(enable) |-> ($stable(phase) && $stable(tod))); // R6

   AST_TICK_SOURCE: assert property (@(posedge clk) disable iff (rst)
      ref_tick |-> (ref_ticks[src_sel] && enable)); // R5

endmodule

// File: tb/sim_ptp_tod_counter.sv
module sim_ptp_tod_counter;

   logic        clk = 1'b0;
   logic        rst;
   logic        wr_en;
   logic [1:0]  wr_addr;
   logic [31:0] wr_data;
   logic [3:0]  ticks;
   logic [63:0] tod0;
   logic        stb0;
   logic [15:0] tod1;
   logic        stb1;

   always #10 clk = ~clk;

   ptp_tod_counter u0 (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .ref_ticks(ticks), .tod(tod0), .tod_strobe(stb0)
   );

   ptp_tod_counter #(.TIME_W(16), .PERIOD_W(16), .DEF_PERIOD(16'd10)) u1 (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .ref_ticks(ticks), .tod(tod1), .tod_strobe(stb1)
   );

   // reference model
   bit          m_en;
   logic [1:0]  m_sel;
   logic [31:0] m_per;
   logic [31:0] m_add;
   logic [31:0] m_acc;
   logic [63:0] m_tod;
   logic [15:0] m_tod1;

   // scoreboard
   logic [63:0] q_tod[$];
   logic [15:0] q_tod1[$];
   logic        q_stb[$];
   string       q_tag[$];

   int  total = 0;
   int  bad   = 0;
   bit  mon_on = 1'b0;
   bit  done   = 1'b0;

   task automatic step(input logic [3:0] tk, input bit we, input logic [1:0] a,
                       input logic [31:0] d, input string tag);
      logic [32:0] s;
      bit c;
      @(negedge clk);
      ticks = tk; wr_en = we; wr_addr = a; wr_data = d;
      c = 1'b0;
      if (m_en && tk[m_sel]) begin
         s = {1'b0, m_acc} + {1'b0, m_add};
         m_acc = s[31:0];
         c = s[32];
         if (c) begin
            m_tod  = m_tod + {32'd0, m_per};
            m_tod1 = m_tod1 + m_per[15:0];
         end
      end
      if (we) begin
         case (a)
            2'd0: m_en  = d[0];
            2'd1: m_sel = d[1:0];
            2'd2: m_per = d;
            default: m_add = d;
         endcase
      end
      q_tod.push_back(m_tod);
      q_tod1.push_back(m_tod1);
      q_stb.push_back(c);
      q_tag.push_back(tag);
   endtask

   task automatic idle(input int n, input string tag);
      for (int i = 0; i < n; i++) step(4'b0000, 1'b0, 2'd0, 32'd0, tag);
   endtask

   task automatic direct(input bit ok, input string tag, input logic [63:0] act,
                         input logic [63:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // monitor: samples a quarter period after each rising edge
   initial begin
      forever begin
         @(posedge clk);
         #5;
         if (mon_on && q_tod.size() > 0) begin
            logic [63:0] et;
            logic [15:0] et1;
            logic        es;
            string       tg;
            et = q_tod.pop_front();
            et1 = q_tod1.pop_front();
            es = q_stb.pop_front();
            tg = q_tag.pop_front();
            total++;
            if (tod0 !== et || stb0 !== es || tod1 !== et1 || stb1 !== es) begin
               bad++;
               $display("FAIL %s: actual tod=%0h stb=%0b narrow=%0h/%0b expected tod=%0h stb=%0b narrow=%0h",
                        tg, tod0, stb0, tod1, stb1, et, es, et1);
            end
         end
      end
   end

   // watchdog
   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         bad++;
         total++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      rst = 1'b1; wr_en = 1'b0; wr_addr = 2'd0; wr_data = 32'd0; ticks = 4'd0;
      m_en = 1'b0; m_sel = 2'd1; m_per = 32'd10; m_add = 32'h8000_0000;
      m_acc = 32'd0; m_tod = 64'd0; m_tod1 = 16'd0;
      repeat (3) @(negedge clk);
      direct(tod0 == 64'd0 && tod1 == 16'd0, "R1 reset time", tod0, 64'd0);
      direct(stb0 == 1'b0 && stb1 == 1'b0, "R1 reset strobe", {63'd0, stb0}, 64'd0);
      rst = 1'b0;
      mon_on = 1'b1;

      // R1: default selector is source 1, default period and addend
      step(4'b0000, 1'b1, 2'd0, 32'd1, "R9 enable write");
      step(4'b0001, 1'b0, 2'd0, 32'd0, "R1 source0 ignored by default");
      step(4'b0010, 1'b0, 2'd0, 32'd0, "R1 default source tick");
      step(4'b0010, 1'b0, 2'd0, 32'd0, "R1 default carry adds 10");
      idle(2, "R4 idle hold");

      // R5: every selector value, with the other sources toggling
      for (int s = 0; s < 4; s++) begin
         step(4'b0000, 1'b1, 2'd1, 32'(s), "R5 select write");
         for (int k = 0; k < 3; k++) step(~(4'b0001 << s), 1'b0, 2'd0, 32'd0, "R5 unselected ignored");
         for (int k = 0; k < 3; k++) step(4'b0001 << s, 1'b0, 2'd0, 32'd0, "R5 selected source");
      end

      // R9: write and tick in the same cycle use the old setting
      step(4'b1111, 1'b1, 2'd2, 32'd25, "R9 period write with tick");
      step(4'b1111, 1'b0, 2'd0, 32'd0, "R3 new period applies");
      step(4'b1111, 1'b0, 2'd0, 32'd0, "R3 new period applies");

      // R7: residue kept across addend change
      step(4'b0000, 1'b1, 2'd3, 32'hC000_0000, "R7 addend write");
      for (int k = 0; k < 3; k++) step(4'b1000, 1'b0, 2'd0, 32'd0, "R7 addend 3/4");
      step(4'b0000, 1'b1, 2'd3, 32'h4000_0000, "R7 addend rewrite");
      for (int k = 0; k < 5; k++) step(4'b1000, 1'b0, 2'd0, 32'd0, "R7 residue carried");

      // R6: disabled counter ignores ticks
      step(4'b0000, 1'b1, 2'd0, 32'd0, "R6 disable");
      for (int k = 0; k < 6; k++) step(4'b1111, 1'b0, 2'd0, 32'd0, "R6 frozen while disabled");
      step(4'b1111, 1'b1, 2'd0, 32'd1, "R6 re-enable");
      step(4'b1111, 1'b0, 2'd0, 32'd0, "R6 resumes");

      // R8: narrow instance wraps repeatedly
      step(4'b0000, 1'b1, 2'd2, 32'h1234_F000, "R8 large period");
      step(4'b0000, 1'b1, 2'd3, 32'hFFFF_FFFF, "R8 near-full addend");
      for (int k = 0; k < 40; k++) step(4'b1111, 1'b0, 2'd0, 32'd0, "R8 wrap");

      // R2: mixed random traffic
      for (int k = 0; k < 400; k++) begin
         logic [31:0] r;
         logic [1:0]  a;
         bit          we;
         r  = $urandom;
         a  = 2'($urandom % 4);
         we = ($urandom % 8) == 0;
         if (we && a == 2'd0) r[0] = ($urandom % 4) != 0;
         step(4'($urandom), we, a, r, "R2 random accumulation");
      end

      idle(3, "R4 drain");
      @(posedge clk);
      #6;
      direct(q_tod.size() == 0, "R2 scoreboard drained", 64'(q_tod.size()), 64'd0);
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule